// File: doc/BRIEF.md
# Frame Address Register Loader

This block sits behind a configuration packet decoder and owns the two-part frame address register. The decoder opens a write with a one-cycle start strobe that carries the target half (major or minor) and the number of data words that will follow. The data words then arrive one per cycle, each qualified by a valid strobe. The block stores each accepted word in the half it belongs to and presents both the raw halves and their decoded fields to the frame logic.

A one-word write changes only the half it addresses. A two-word write aimed at the major half puts its first word into the major half and its second word into the minor half. Bits that the layout defines as zero are cleared before storage. A start with a word count the target half does not accept sets a sticky error flag and leaves the register untouched. An abort strobe closes an open write at any point, so a two-word write cut off after one word leaves the minor half as it was.

Top module: `frame_addr_loader`

## Requirements
- R1: Asserting `rst_n` low clears both halves and `wr_error` at once. Reset release is synchronised internally, so writes are accepted from the third rising edge after `rst_n` goes high.
- R2: A start with `wr_sel`=0 (major) and count 1 stores the next accepted word in the major half, visible after the edge that takes the word. The major half decodes as block type [15:12], row [11:8] and major column [7:0]. The minor half is unchanged.
- R3: Bit 15 of the major half (the top bit of the block type) is always stored as 0.
- R4: A start with `wr_sel`=1 (minor) and count 1 stores the next accepted word in the minor half. The minor half decodes as block-RAM bits [15:14] and minor frame [9:0]. The major half is unchanged.
- R5: Bits [13:10] of the minor half are always stored as 0, whatever the data word holds.
- R6: A major start with count 2 stores the first word in the major half as soon as it arrives, and the second word in the minor half.
- R7: `wr_abort` closes an open write. A word presented in the abort cycle is dropped, and so is any word that follows. A two-word write aborted after its first word leaves the minor half unchanged.
- R8: A major start with a count other than 1 or 2, or a minor start with a count other than 1, sets `wr_error`, updates neither half, and drops the words that follow it.
- R9: A word presented while no write is open is ignored. This covers a word after a write has received its count, and a word in the same cycle as `wr_start`.
- R10: A `wr_start` arriving while a write is open abandons the old write and begins the new one.
- R11: `wr_error` stays set through later legal writes until reset, and legal writes still take effect while it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start | input | 1 | Opens a write (one cycle) |
| wr_sel | input | 1 | Target half: 0 major, 1 minor |
| wr_count | input | CNT_W | Number of data words in the write |
| wr_abort | input | 1 | Closes the open write |
| word_valid | input | 1 | Data word valid |
| word_data | input | 16 | Data word |
| frame_major | output | 16 | Stored major half |
| frame_minor | output | 16 | Stored minor half |
| blk_type | output | 4 | Block type field |
| row_addr | output | 4 | Row field |
| major_col | output | 8 | Major column field |
| bram_sel | output | 2 | Block-RAM bits of the minor half |
| minor_frame | output | 10 | Minor frame field |
| wr_error | output | 1 | Sticky malformed-write flag |

## Verification
A sequencer left in the wrong state shows up at the ports in two ways, both one edge after the next data word. If it has forgotten an open write, an expected update does not appear. If it still thinks a write is open, a stray word appears in one of the halves. For that reason the bench follows every completed, aborted or rejected write with a stray word and then checks both halves. A wrong count decision shows on `wr_error` one edge after the start strobe. A lost reserved-bit mask shows on `frame_minor` or `frame_major` on the first write of all-ones data.

// File: rtl/fal_pkg.sv
package fal_pkg;

  localparam int FA_WORD_W = 16;

  // Bits that the layout defines as zero in each half
  localparam logic [FA_WORD_W-1:0] MAJ_ZERO_MASK = 16'h8000;
  localparam logic [FA_WORD_W-1:0] MIN_ZERO_MASK = 16'h3C00;

  // Field positions inside the major half
  localparam int BLK_MSB = 15;
  localparam int BLK_LSB = 12;
  localparam int ROW_MSB = 11;
  localparam int ROW_LSB = 8;
  localparam int COL_MSB = 7;
  localparam int COL_LSB = 0;

  // Field positions inside the minor half
  localparam int BRAM_MSB = 15;
  localparam int BRAM_LSB = 14;
  localparam int FRM_MSB  = 9;
  localparam int FRM_LSB  = 0;

  localparam logic SEL_MAJOR = 1'b0;
  localparam logic SEL_MINOR = 1'b1;

  typedef enum logic [1:0] {
    SEQ_IDLE       = 2'd0,
    SEQ_MAJ_WORD   = 2'd1,
    SEQ_MIN_SECOND = 2'd2,
    SEQ_MIN_ONLY   = 2'd3
  } seq_state_e;

endpackage

// File: rtl/fal_rst_sync.sv
module fal_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  generate
    if (STAGES <= 1) begin : g_single
      logic stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= 1'b0;
        else        stage_q <= 1'b1;
      end
      assign rst_n_sync = stage_q;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
      assign rst_n_sync = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/fal_half_reg.sv
module fal_half_reg #(
  parameter int              WIDTH     = 16,
  parameter logic [WIDTH-1:0] ZERO_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);

  logic [WIDTH-1:0] d_clean;
  logic [WIDTH-1:0] val_q;

  always_comb begin
    d_clean = d_in & ~ZERO_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     val_q <= '0;
    else if (ld_en) val_q <= d_clean;
  end

  assign q_out = val_q;

endmodule

// File: rtl/fal_seq.sv
module fal_seq
  import fal_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_start,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_count,
  input  logic             wr_abort,
  input  logic             word_valid,
  output logic             ld_major,
  output logic             ld_minor,
  output logic             err_flag
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_TWO = CNT_W'(2);

  seq_state_e st_q, st_d;
  logic       pair_q, pair_d;
  logic       err_q;
  logic       err_set;

  // Next-state logic: start beats abort, abort beats a data word
  always_comb begin
    st_d     = st_q;
    pair_d   = pair_q;
    ld_major = 1'b0;
    ld_minor = 1'b0;
    err_set  = 1'b0;
    if (wr_start) begin
      pair_d = 1'b0;
      if (wr_sel == SEL_MAJOR) begin
        if (wr_count == CNT_ONE) begin
          st_d = SEQ_MAJ_WORD;
        end else if (wr_count == CNT_TWO) begin
          st_d   = SEQ_MAJ_WORD;
          pair_d = 1'b1;
        end else begin
          st_d    = SEQ_IDLE;
          err_set = 1'b1;
        end
      end else begin
        if (wr_count == CNT_ONE) begin
          st_d = SEQ_MIN_ONLY;
        end else begin
          st_d    = SEQ_IDLE;
          err_set = 1'b1;
        end
      end
    end else if (wr_abort) begin
      st_d   = SEQ_IDLE;
      pair_d = 1'b0;
    end else if (word_valid) begin
      unique case (st_q)
        SEQ_MAJ_WORD: begin
          ld_major = 1'b1;
          st_d     = pair_q ? SEQ_MIN_SECOND : SEQ_IDLE;
          pair_d   = 1'b0;
        end
        SEQ_MIN_SECOND, SEQ_MIN_ONLY: begin
          ld_minor = 1'b1;
          st_d     = SEQ_IDLE;
        end
        default: begin
          st_d = SEQ_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      pair_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pair_q <= pair_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (err_set) err_q <= 1'b1;
  end

  assign err_flag = err_q;

endmodule

// File: rtl/frame_addr_loader.sv
module frame_addr_loader
  import fal_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_start,
  input  logic                 wr_sel,
  input  logic [CNT_W-1:0]     wr_count,
  input  logic                 wr_abort,
  input  logic                 word_valid,
  input  logic [FA_WORD_W-1:0] word_data,
  output logic [FA_WORD_W-1:0] frame_major,
  output logic [FA_WORD_W-1:0] frame_minor,
  output logic [3:0]           blk_type,
  output logic [3:0]           row_addr,
  output logic [7:0]           major_col,
  output logic [1:0]           bram_sel,
  output logic [9:0]           minor_frame,
  output logic                 wr_error
);

  logic rst_ns;
  logic ld_major, ld_minor;

  fal_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  fal_seq #(.CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_ns),
    .wr_start   (wr_start),
    .wr_sel     (wr_sel),
    .wr_count   (wr_count),
    .wr_abort   (wr_abort),
    .word_valid (word_valid),
    .ld_major   (ld_major),
    .ld_minor   (ld_minor),
    .err_flag   (wr_error)
  );

  fal_half_reg #(.WIDTH(FA_WORD_W), .ZERO_MASK(MAJ_ZERO_MASK)) u_major (
    .clk   (clk),
    .rst_n (rst_ns),
    .ld_en (ld_major),
    .d_in  (word_data),
    .q_out (frame_major)
  );

  fal_half_reg #(.WIDTH(FA_WORD_W), .ZERO_MASK(MIN_ZERO_MASK)) u_minor (
    .clk   (clk),
    .rst_n (rst_ns),
    .ld_en (ld_minor),
    .d_in  (word_data),
    .q_out (frame_minor)
  );

  assign blk_type    = frame_major[BLK_MSB:BLK_LSB];
  assign row_addr    = frame_major[ROW_MSB:ROW_LSB];
  assign major_col   = frame_major[COL_MSB:COL_LSB];
  assign bram_sel    = frame_minor[BRAM_MSB:BRAM_LSB];
  assign minor_frame = frame_minor[FRM_MSB:FRM_LSB];

endmodule

// File: rtl/fal_checker.sv
module fal_checker (
  input logic        clk,
  input logic        rst_n_s,
  input logic        wr_start,
  input logic        wr_abort,
  input logic        word_valid,
  input logic [15:0] frame_major,
  input logic [15:0] frame_minor,
  input logic        wr_error
);

  assert_blk_msb_zero_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    frame_major[15] == 1'b0);

  assert_rsvd_zero_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    frame_minor[13:10] == 4'b0000);

  assert_minor_needs_word_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    !$stable(frame_minor) |-> $past(word_valid));

  assert_abort_no_load_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_abort |=> ($stable(frame_major) && $stable(frame_minor)));

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_error |=> wr_error);

  assert_err_from_start_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(wr_error) |-> $past(wr_start));

  assert_start_no_load_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_start |=> ($stable(frame_major) && $stable(frame_minor)));

endmodule

bind frame_addr_loader fal_checker u_fal_checker (
  .clk         (clk),
  .rst_n_s     (rst_ns),
  .wr_start    (wr_start),
  .wr_abort    (wr_abort),
  .word_valid  (word_valid),
  .frame_major (frame_major),
  .frame_minor (frame_minor),
  .wr_error    (wr_error)
);

// File: tb/frame_addr_loader_bench.sv
`timescale 1ns/1ps
module frame_addr_loader_bench;

  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_start = 1'b0;
  logic             wr_sel = 1'b0;
  logic [CNT_W-1:0] wr_count = '0;
  logic             wr_abort = 1'b0;
  logic             word_valid = 1'b0;
  logic [15:0]      word_data = '0;
  logic [15:0]      frame_major, frame_minor;
  logic [3:0]       blk_type, row_addr;
  logic [7:0]       major_col;
  logic [1:0]       bram_sel;
  logic [9:0]       minor_frame;
  logic             wr_error;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [15:0] maj;
    logic [15:0] mnr;
    logic        err;
    string       tag;
  } exp_item_t;

  exp_item_t sb_q[$];

  always #2 clk = ~clk;

  frame_addr_loader #(.CNT_W(CNT_W)) u_frame_addr_loader (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_sel(wr_sel),
    .wr_count(wr_count), .wr_abort(wr_abort), .word_valid(word_valid),
    .word_data(word_data), .frame_major(frame_major), .frame_minor(frame_minor),
    .blk_type(blk_type), .row_addr(row_addr), .major_col(major_col),
    .bram_sel(bram_sel), .minor_frame(minor_frame), .wr_error(wr_error)
  );

  task automatic clear_inputs();
    wr_start = 1'b0; wr_abort = 1'b0; word_valid = 1'b0;
  endtask

  task automatic do_start(input logic sel, input int cnt);
    @(negedge clk);
    clear_inputs();
    wr_start = 1'b1; wr_sel = sel; wr_count = CNT_W'(cnt);
  endtask

  task automatic do_word(input logic [15:0] d);
    @(negedge clk);
    clear_inputs();
    word_valid = 1'b1; word_data = d;
  endtask

  task automatic do_abort(input logic with_word, input logic [15:0] d);
    @(negedge clk);
    clear_inputs();
    wr_abort = 1'b1; word_valid = with_word; word_data = d;
  endtask

  // Driver side of the scoreboard: idle cycle, then push the expectation
  task automatic expect_state(input logic [15:0] maj, input logic [15:0] mnr,
                              input logic err, input string tag);
    exp_item_t it;
    @(negedge clk);
    clear_inputs();
    it.maj = maj; it.mnr = mnr; it.err = err; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor side of the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        exp_item_t it;
        it = sb_q.pop_front();
        checks++;
        if (frame_major !== it.maj || frame_minor !== it.mnr || wr_error !== it.err) begin
          fails++;
          $display("FAIL %s: major=%h minor=%h err=%b expected major=%h minor=%h err=%b",
                   it.tag, frame_major, frame_minor, wr_error, it.maj, it.mnr, it.err);
        end
        checks++;
        if (blk_type !== it.maj[15:12] || row_addr !== it.maj[11:8] ||
            major_col !== it.maj[7:0] || bram_sel !== it.mnr[15:14] ||
            minor_frame !== it.mnr[9:0]) begin
          fails++;
          $display("FAIL %s fields: blk=%h row=%h col=%h bram=%h frm=%h expected blk=%h row=%h col=%h bram=%h frm=%h",
                   it.tag, blk_type, row_addr, major_col, bram_sel, minor_frame,
                   it.maj[15:12], it.maj[11:8], it.maj[7:0], it.mnr[15:14], it.mnr[9:0]);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_state(16'h0000, 16'h0000, 1'b0, "R1 reset state");

    do_start(1'b0, 1); do_word(16'hFABC);
    expect_state(16'h7ABC, 16'h0000, 1'b0, "R2 R3 major one-word");
    do_word(16'hFFFF);
    expect_state(16'h7ABC, 16'h0000, 1'b0, "R9 word after completed write");

    do_start(1'b1, 1); do_word(16'hFFFF);
    expect_state(16'h7ABC, 16'hC3FF, 1'b0, "R4 R5 minor one-word");

    do_start(1'b0, 2); do_word(16'h1234);
    expect_state(16'h1234, 16'hC3FF, 1'b0, "R6 first word of pair");
    do_word(16'h5678);
    expect_state(16'h1234, 16'h4278, 1'b0, "R6 second word of pair");
    do_word(16'h9999);
    expect_state(16'h1234, 16'h4278, 1'b0, "R9 word after pair");

    do_start(1'b0, 2); do_word(16'h0AAA); do_abort(1'b0, 16'h0);
    expect_state(16'h0AAA, 16'h4278, 1'b0, "R7 pair cut after one word");
    do_word(16'h0001);
    expect_state(16'h0AAA, 16'h4278, 1'b0, "R7 word after abort");

    do_start(1'b0, 3); do_word(16'h1111);
    expect_state(16'h0AAA, 16'h4278, 1'b1, "R8 major count 3");
    do_start(1'b1, 2); do_word(16'h2222);
    expect_state(16'h0AAA, 16'h4278, 1'b1, "R8 minor count 2");
    do_start(1'b0, 0); do_word(16'h3333);
    expect_state(16'h0AAA, 16'h4278, 1'b1, "R8 major count 0");

    do_start(1'b0, 1); do_word(16'h2345);
    expect_state(16'h2345, 16'h4278, 1'b1, "R11 legal write with error set");

    do_start(1'b0, 2); do_word(16'h3333);
    do_start(1'b1, 1); do_word(16'h8001);
    expect_state(16'h3333, 16'h8001, 1'b1, "R10 restart during open pair");

    do_start(1'b0, 1); do_abort(1'b1, 16'h7777);
    expect_state(16'h3333, 16'h8001, 1'b1, "R7 word in abort cycle");

    @(negedge clk);
    wr_start = 1'b1; wr_sel = 1'b1; wr_count = CNT_W'(1);
    word_valid = 1'b1; word_data = 16'h0155;
    expect_state(16'h3333, 16'h8001, 1'b1, "R9 word with start");
    do_word(16'h4002);
    expect_state(16'h3333, 16'h4002, 1'b1, "R4 minor after start-cycle word");

    @(negedge clk);
    rst_n = 1'b0;
    expect_state(16'h0000, 16'h0000, 1'b0, "R1 reset mid-run");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    do_start(1'b0, 1); do_word(16'h5555);
    expect_state(16'h5555, 16'h0000, 1'b0, "R1 R2 write after reset");

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule